// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-side protocol engine of a 128-byte serial memory reached over a two-wire clock/data bus. A fast system clock samples the clock (SCL) and data (SDA) lines. The block finds start and stop conditions and decodes the first byte of each transfer. That byte holds a 7-bit word address followed by a direction bit. No separate device-select byte exists.

The engine acknowledges by pulling SDA low through an open-drain enable. In a read it serves data from an external synchronous 128x8 read port and walks the whole address space. In a write it hands each received byte, with its target address, to a page-write controller. When a stop ends a write transfer, it tells that controller to commit. While the controller reports an internal write cycle, the engine stays off the bus.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset, and until a start condition (SDA falling while SCL is high) is seen, bus clocking produces no acknowledge and no forwarded write byte.
- R2: After a start, the first byte is taken in MSB first on SCL rising edges: seven word-address bits, then a direction bit where 1 means read and 0 means write. The block acknowledges by driving SDA low for the whole ninth clock.
- R3: In a write transfer each data byte is acknowledged on its ninth clock. Each one is forwarded as a one-cycle `wr_valid` pulse carrying `wr_addr` and `wr_data`.
- R4: Between write bytes, only the two low address bits count up, wrapping from 3 to 0. The upper five bits are kept, so a fifth byte goes to the same address as the first.
- R5: In a read transfer the block sends the byte at `rd_addr` MSB first, with each bit changing after an SCL falling edge. It releases SDA on the ninth clock. If the master acknowledges (SDA low), the next byte follows.
- R6: In a sequential read the address advances over all seven bits and wraps from 127 to 0.
- R7: If the master does not acknowledge a read byte, the block releases SDA and stays silent until the next start.
- R8: While `busy_i` is high, an address byte receives no acknowledge and the block does not respond for the rest of that transfer.
- R9: A stop condition (SDA rising while SCL is high) returns the block to idle, where clocking without a new start gets no response. The stop produces one `wr_commit` pulse if at least one write byte was received since the last start, and no pulse otherwise.
- R10: A start that arrives in the middle of a byte abandons that byte and begins a new address phase.
- R11: `sda_oe` = 1 means pull SDA low and 0 means release. It changes only while SCL is low, never during the high phase of a clock.
- R12: Under reset `sda_oe`, `wr_valid` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| rd_addr | output | 7 | Address presented to the synchronous read port |
| rd_data | input | 8 | Read-port data, valid one cycle after rd_addr |
| wr_valid | output | 1 | One-cycle pulse: a write byte was received |
| wr_addr | output | 7 | Target address of the forwarded write byte |
| wr_data | output | 8 | Forwarded write byte |
| wr_commit | output | 1 | One-cycle pulse on stop after a write transfer |
| busy_i | input | 1 | Internal write cycle in progress |

## Verification
A bit counter that is out of step shows up at the very next ninth clock. Either the acknowledge lands one SCL period early or late, or a read byte arrives rotated, so the master sees it within one byte time. A wrong address counter shows only when bytes are compared against their expected location. For that reason, page wrap and the 127-to-0 wrap are read back across their boundaries. A direction or idle state that is stuck leaves `sda_oe` driving when it should release. That is caught on the same SCL high phase, both by the master's sampling and by a check on every system clock that the enable holds steady while SCL is high.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } twm_state_e;
endpackage

// File: rtl/twm_bus_front.sv
// Synchronises SCL and SDA into the system clock domain and derives
// edge and start/stop events from the synchronised values.
module twm_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int NL = 2;  // bit 1 = SCL, bit 0 = SDA

  logic [NL-1:0] raw_w;
  logic [NL-1:0] cur;
  logic [NL-1:0] prv;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[SYNC_STAGES-2:0], raw_w[g]};
    end
    assign cur[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= cur;
  end

  assign sda_bit   = cur[0];
  assign scl_rise  = cur[1] & ~prv[1];
  assign scl_fall  = ~cur[1] & prv[1];
  assign start_evt = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_evt  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/twm_addr_ctr.sv
// Word address counter: full-width increment for reads, page-limited
// increment for writes.
module twm_addr_ctr #(
  parameter int AW = 7,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_rd,
  input  logic          inc_wr,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] wr_next;

  if (PW == 0) begin : g_byte
    assign wr_next = addr;
  end else if (PW >= AW) begin : g_flat
    assign wr_next = addr + AW'(1);
  end else begin : g_page
    assign wr_next = {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
  end

  always_ff @(posedge clk) begin
    if (rst)         addr <= '0;
    else if (load)   addr <= load_val;
    else if (inc_rd) addr <= addr + AW'(1);
    else if (inc_wr) addr <= wr_next;
  end

  if (PW > 0 && PW < AW) begin : g_page_chk
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (inc_wr && !load && !inc_rd) |=> addr[AW-1:PW] == $past(addr[AW-1:PW])); // R4
  end

  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_rd && !load) |=> addr == $past(addr) + AW'(1)); // R6
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PAGE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_commit,
  input  logic          busy_i
);
  import twm_pkg::*;

  // The address byte is AW address bits plus one direction bit, so AW+1 == DW.
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic sda_bit, scl_rise, scl_fall, start_evt, stop_evt;

  twm_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_bit  (sda_bit),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  twm_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx;
  logic          rw;
  logic          mack;
  logic          pend;

  logic          ld_addr, inc_rd, inc_wr;
  logic [AW-1:0] addr;

  assign ld_addr = (state == ST_ADDR)  && scl_fall && (cnt == FULL) && !busy_i;
  assign inc_wr  = (state == ST_WDATA) && scl_fall && (cnt == FULL);
  assign inc_rd  = (state == ST_RDATA) && scl_fall && (cnt == FULL);

  twm_addr_ctr #(.AW(AW), .PW(PAGE_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (ld_addr),
    .load_val(sh[AW:1]),
    .inc_rd  (inc_rd),
    .inc_wr  (inc_wr),
    .addr    (addr)
  );

  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      pend      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        pend   <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        wr_commit <= pend;
        pend      <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_bit};
              cnt <= cnt + CW'(1);
            end else if (scl_fall && cnt == FULL) begin
              if (busy_i) begin
                state <= ST_IDLE;
              end else begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                state  <= ST_RDATA;
                tx     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                state  <= ST_WDATA;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_bit};
              cnt <= cnt + CW'(1);
            end else if (scl_fall && cnt == FULL) begin
              wr_valid <= 1'b1;
              wr_addr  <= addr;
              wr_data  <= sh;
              pend     <= 1'b1;
              sda_oe   <= 1'b1;
              state    <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + CW'(1);
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                tx     <= {tx[DW-2:0], 1'b0};
                sda_oe <= ~tx[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_bit;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= ST_RDATA;
                cnt    <= '0;
                tx     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R7

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_ADDR && state == ST_AACK) |-> !$past(busy_i)); // R8

  AST_WRV_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R3

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(stop_evt)); // R9
endmodule

// File: tb/test_twowire_mem_slave.sv
module test_twowire_mem_slave;
  localparam int BUSY_CYC = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_line;
  logic       sda_oe;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       wr_valid;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       wr_commit;
  logic       busy;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_line = ~(m_low | sda_oe);

  twowire_mem_slave i_twowire_mem_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit), .busy_i(busy)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural array and page-write controller; records forwarded writes.
  logic [7:0] mem [128];
  int         busy_cnt;
  int         commits;
  int         mon_a [$];
  int         mon_d [$];
  int         pend_a [$];
  int         pend_d [$];

  assign busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'((i * 37 + 11) & 255);
      busy_cnt <= 0;
      commits  <= 0;
      rd_data  <= 8'h00;
    end else begin
      rd_data <= mem[rd_addr];
      if (wr_valid) begin
        mon_a.push_back(int'(wr_addr));
        mon_d.push_back(int'(wr_data));
        pend_a.push_back(int'(wr_addr));
        pend_d.push_back(int'(wr_data));
      end
      if (wr_commit) begin
        foreach (pend_a[k]) mem[pend_a[k]] <= 8'(pend_d[k]);
        pend_a.delete();
        pend_d.delete();
        busy_cnt <= BUSY_CYC;
        commits  <= commits + 1;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  // Per-clock model of R11: the enable must hold still through each SCL high phase.
  int hi_cnt = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (scl_m) hi_cnt <= hi_cnt + 1;
    else       hi_cnt <= 0;
    if (!rst && hi_cnt >= 5 && sda_oe != oe_prev) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic bit_cycle(input bit b, output bit seen);
    m_low = ~b;
    q();
    scl_m = 1'b1;
    q();
    seen = sda_line;
    q();
    scl_m = 1'b0;
    q();
  endtask

  task automatic bus_start();
    m_low = 1'b0; q();
    scl_m = 1'b1; q();
    m_low = 1'b1; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; q();
    scl_m = 1'b1; q();
    m_low = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~give_ack, s);
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  logic [7:0] exp_mem [128];

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit         a;
    logic [7:0] b;
    int         base;
    int         c0;
    logic [7:0] pg [5];
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'((i * 37 + 11) & 255);

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0, "R12 reset outputs",
        int'({sda_oe, wr_valid, wr_commit}), 0);
    rst = 1'b0;
    q();

    // R1: clock a write address and data byte without a start
    scl_m = 1'b0; q();
    send_byte({7'h05, 1'b0}, a);
    chk(!a, "R1 no ack before start", a, 0);
    send_byte(8'h5A, a);
    chk(mon_a.size() == 0, "R1 no write forwarded", mon_a.size(), 0);

    // R2/R3: byte write of A5 to address 5
    base = mon_a.size();
    c0 = commits;
    bus_start();
    send_byte({7'h05, 1'b0}, a);
    chk(a, "R2 address ack", a, 1);
    send_byte(8'hA5, a);
    chk(a, "R3 data ack", a, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(mon_a.size() == base + 1 && mon_a[base] == 5 && mon_d[base] == 8'hA5,
        "R3 forwarded byte", (mon_a.size() > base) ? mon_d[base] : -1, 8'hA5);
    chk(commits == c0 + 1, "R9 commit on stop", commits - c0, 1);
    exp_mem[5] = 8'hA5;

    // R8: poll while the internal write is running
    bus_start();
    send_byte({7'h05, 1'b0}, a);
    chk(!a, "R8 no ack while busy", a, 0);
    send_byte(8'h77, a);
    chk(!a, "R8 silent for rest of transfer", a, 0);
    bus_stop();
    wait_idle();
    c0 = commits;
    bus_start();
    send_byte({7'h05, 1'b0}, a);
    chk(a, "R8 ack once idle", a, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(commits == c0, "R9 no commit without data", commits - c0, 0);

    // R5: byte read
    bus_start();
    send_byte({7'h05, 1'b1}, a);
    chk(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, b);
    chk(b == exp_mem[5], "R5 byte read", b, exp_mem[5]);
    bus_stop();

    // R4: page write of five bytes from 0x0E
    base = mon_a.size();
    pg[0] = 8'h11; pg[1] = 8'h22; pg[2] = 8'h33; pg[3] = 8'h44; pg[4] = 8'h55;
    bus_start();
    send_byte({7'h0E, 1'b0}, a);
    for (int k = 0; k < 5; k++) begin
      send_byte(pg[k], a);
      chk(a, "R3 page byte ack", a, 1);
    end
    bus_stop();
    for (int k = 0; k < 5; k++) begin
      int ea;
      ea = 8'h0C + ((2 + k) % 4);
      chk(mon_a.size() > base + k && mon_a[base + k] == ea, "R4 page address",
          (mon_a.size() > base + k) ? mon_a[base + k] : -1, ea);
      exp_mem[ea] = pg[k];
    end
    wait_idle();

    // R4/R5: read the page back sequentially
    bus_start();
    send_byte({7'h0C, 1'b1}, a);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, b);
      chk(b == exp_mem[12 + k], "R4 page readback", b, exp_mem[12 + k]);
    end
    bus_stop();

    // R6: sequential read across 127 -> 0
    bus_start();
    send_byte({7'h7E, 1'b1}, a);
    for (int k = 0; k < 4; k++) begin
      int ea;
      ea = (126 + k) % 128;
      recv_byte(k != 3, b);
      chk(b == exp_mem[ea], "R6 wrap read", b, exp_mem[ea]);
    end
    bus_stop();

    // R7: after a NACK the block stays silent
    bus_start();
    send_byte({7'h10, 1'b1}, a);
    recv_byte(1'b0, b);
    chk(b == exp_mem[16], "R5 read before nack", b, exp_mem[16]);
    recv_byte(1'b1, b);
    chk(b == 8'hFF, "R7 silent after nack", b, 8'hFF);
    bus_stop();

    // R10: start in the middle of a byte
    base = mon_a.size();
    bus_start();
    bit_cycle(1'b1, a); bit_cycle(1'b0, a); bit_cycle(1'b1, a); bit_cycle(1'b0, a);
    bus_start();
    send_byte({7'h33, 1'b0}, a);
    chk(a, "R10 new address phase ack", a, 1);
    send_byte(8'h9C, a);
    bus_stop();
    chk(mon_a.size() == base + 1 && mon_a[base] == 8'h33, "R10 address after restart",
        (mon_a.size() > base) ? mon_a[base] : -1, 8'h33);
    exp_mem[8'h33] = 8'h9C;
    wait_idle();
    bus_start();
    send_byte({7'h33, 1'b1}, a);
    recv_byte(1'b0, b);
    chk(b == 8'h9C, "R10 restart data stored", b, 8'h9C);
    bus_stop();

    // R9: after stop, clocking without a start gets nothing
    scl_m = 1'b0; q();
    send_byte({7'h05, 1'b1}, a);
    chk(!a, "R9 idle after stop", a, 0);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R9 no data driven when idle", b, 8'hFF);
    bus_stop();

    chk(oe_viol == 0, "R11 enable steady while SCL high", oe_viol, 0);
    summary();
  end
endmodule